// File: doc/BRIEF.md
# Gated Programmable Output Clock Divider

This block turns a fast, free-running source clock into a slower output clock whose ratio is picked by a 2-bit code. The output keeps an even duty cycle at every ratio. The block runs on a clock at twice the nominal source rate, so that divide-by-1 can be built from registers alone. One output period lasts 2N cycles of that clock, where N is the selected ratio.

A low-power input stretches the output by a further factor of 16. An enable input parks the output at a static level. Ratio, low-power and enable changes are taken up only at the end of a low half-period. A period that has already begun always completes with its old settings, so no shortened high or low pulse ever reaches the output. While the output is parked, the control inputs are sampled on every cycle.

Top module: `odiv_gated_out`

## Requirements
- R1: The ratio code maps non-monotonically to the divide ratio N: code 2'b11 gives N=1, 2'b00 gives N=2, 2'b01 gives N=4 and 2'b10 gives N=8. One output period lasts 2N clock cycles.
- R2: With low power off, clk_out is high for exactly N cycles and then low for exactly N cycles, for every code.
- R3: With pwr_down at 1, each half-period lasts 16N cycles, for every code.
- R4: While the active enable is 0, clk_out is held at 0 and clk_out_n at 1.
- R5: New values of ratio_code, pwr_down and out_en take effect only at the end of a low half-period. A period already in progress finishes both halves with the previous settings.
- R6: Dropping out_en during a high half does not cut that half short. The high half runs its full length, the low half follows, and the output then stays low.
- R7: While rst_n is low, clk_out is 0. At the first clock edge after release, the inputs are loaded, and if out_en is 1 the output is high after that edge.
- R8: clk_out_n is always the complement of clk_out.
- R9: While the output is parked, raising out_en makes clk_out go high at the next clock edge, with the ratio present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the nominal source rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ratio_code | input | 2 | Divide ratio code (see R1) |
| pwr_down | input | 1 | 1 stretches each half-period by 16 |
| out_en | input | 1 | Active-high output enable |
| clk_out | output | 1 | Divided output clock |
| clk_out_n | output | 1 | Complement of clk_out |

## Verification
The bench sweeps all four ratio codes, each with low power off and on, and measures the high and low run lengths of a settled period. This sweep separates a wrong code mapping from a wrong duty split or a missing stretch factor. A ratio change made at the start of a high half shows whether the running period finishes with its old length. Dropping the enable mid-high shows whether the last pulse runs its full length. Raising the enable while parked, and releasing reset, confirm the single-cycle response.

// File: rtl/odiv_pkg.sv
package odiv_pkg;

  // Active configuration of the divider
  typedef struct packed {
    logic [1:0] code;
    logic       pd;
    logic       en;
  } odiv_cfg_t;

  localparam int RATIO_LOG2_MAX = 3;

  // Log2 of the divide ratio for a code (non-monotonic mapping)
  function automatic int ratio_log2(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 3;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/odiv_half_len.sv
module odiv_half_len
  import odiv_pkg::*;
#(
  parameter int PD_SHIFT = 4,
  localparam int CNT_W   = RATIO_LOG2_MAX + PD_SHIFT
) (
  input  odiv_cfg_t        cfg,
  output logic [CNT_W-1:0] last_cnt
);

  logic [CNT_W:0] half_len;
  int             shift_amt;

  always_comb begin
    shift_amt = ratio_log2(cfg.code);
    if (cfg.pd) begin
      shift_amt = shift_amt + PD_SHIFT;
    end
    half_len = (CNT_W+1)'(1) << shift_amt;
    last_cnt = CNT_W'(half_len - (CNT_W+1)'(1));
  end

endmodule

// File: rtl/odiv_cfg_hold.sv
module odiv_cfg_hold
  import odiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  odiv_cfg_t cfg_in,
  output odiv_cfg_t cfg_q
);

  odiv_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) begin
      cfg_d = cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/odiv_phase_ctr.sv
module odiv_phase_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] last_cnt,
  input  logic             en_act,
  input  logic             en_next,
  output logic             out_q,
  output logic             boundary
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             out_d;
  logic             at_last;

  always_comb begin
    at_last  = (cnt_q == last_cnt);
    // End of a low half, or parked: reload point
    boundary = !out_q && (at_last || !en_act);
    cnt_d    = cnt_q + CNT_W'(1);
    out_d    = out_q;
    if (boundary) begin
      cnt_d = '0;
      out_d = en_next;
    end else if (at_last) begin
      cnt_d = '0;
      out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/odiv_gated_out.sv
module odiv_gated_out
  import odiv_pkg::*;
#(
  parameter int PD_SHIFT = 4,
  localparam int CNT_W   = RATIO_LOG2_MAX + PD_SHIFT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_code,
  input  logic       pwr_down,
  input  logic       out_en,
  output logic       clk_out,
  output logic       clk_out_n
);

  odiv_cfg_t        cfg_in;
  odiv_cfg_t        cfg_q;
  logic [CNT_W-1:0] last_cnt;
  logic             boundary;
  logic             out_q;

  always_comb begin
    cfg_in.code = ratio_code;
    cfg_in.pd   = pwr_down;
    cfg_in.en   = out_en;
  end

  odiv_cfg_hold u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (boundary),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  odiv_half_len #(.PD_SHIFT(PD_SHIFT)) u_len (
    .cfg      (cfg_q),
    .last_cnt (last_cnt)
  );

  odiv_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_cnt (last_cnt),
    .en_act   (cfg_q.en),
    .en_next  (out_en),
    .out_q    (out_q),
    .boundary (boundary)
  );

  assign clk_out   = out_q;
  assign clk_out_n = ~out_q;

endmodule

// File: rtl/odiv_gated_out_chk.sv
module odiv_gated_out_chk
  import odiv_pkg::*;
#(
  parameter int PD_SHIFT = 4
) (
  input logic      clk,
  input logic      rst_n,
  input logic      clk_out,
  input odiv_cfg_t act_cfg
);

  logic [15:0] run_q;
  logic        prev_q;
  logic [15:0] exp_half;

  // Independent half-length model of the active configuration
  always_comb begin
    case (act_cfg.code)
      2'b00:   exp_half = 16'd2;
      2'b01:   exp_half = 16'd4;
      2'b10:   exp_half = 16'd8;
      default: exp_half = 16'd1;
    endcase
    if (act_cfg.pd) begin
      exp_half = exp_half << PD_SHIFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= clk_out;
      if (clk_out != prev_q) begin
        run_q <= 16'd1;
      end else if (run_q != 16'hFFFF) begin
        run_q <= run_q + 16'd1;
      end
    end
  end

  // High half length per code and power-down (also covers R1, R3)
  assert_high_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_out) && prev_q) |-> (run_q == exp_half));

  // Low half length uses the settings of the period it belongs to (R5)
  assert_low_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_out) && !prev_q && $past(act_cfg.en)) |-> (run_q == $past(exp_half)));

  assert_cfg_at_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cfg) |-> !$past(clk_out));

  assert_parked_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !act_cfg.en |-> !clk_out);

endmodule

bind odiv_gated_out odiv_gated_out_chk #(.PD_SHIFT(PD_SHIFT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk_out (clk_out),
  .act_cfg (cfg_q)
);

// File: tb/odiv_gated_out_bench.sv
module odiv_gated_out_bench;

  logic       clk;
  logic       rst_n;
  logic [1:0] ratio_code;
  logic       pwr_down;
  logic       out_en;
  logic       clk_out;
  logic       clk_out_n;

  int checks;
  int errors;
  int comp_err;
  int cycles;
  bit done;

  odiv_gated_out u_odiv_gated_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .pwr_down   (pwr_down),
    .out_en     (out_en),
    .clk_out    (clk_out),
    .clk_out_n  (clk_out_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ratio_of(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (clk_out_n !== ~clk_out) comp_err++;
  endtask

  // Counts from the first cycle of a high half up to the next rise
  task automatic count_period(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (clk_out === 1'b1) begin hi++; step(); end
    while (clk_out === 1'b0) begin lo++; step(); end
  endtask

  task automatic measure(output int hi, output int lo);
    while (clk_out !== 1'b0) step();
    while (clk_out !== 1'b1) step();
    count_period(hi, lo);
  endtask

  task automatic finish_run();
    chk(comp_err == 0, "R8 complement", comp_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    int hi;
    int lo;
    int exp_h;
    bit stayed;
    checks = 0; errors = 0; comp_err = 0; done = 0;
    rst_n = 1'b0;
    ratio_code = 2'b11; pwr_down = 1'b0; out_en = 1'b1;
    repeat (4) step();
    chk(clk_out === 1'b0, "R7 reset out", int'(clk_out), 0);
    chk(clk_out_n === 1'b1, "R8 reset out_n", int'(clk_out_n), 1);
    rst_n = 1'b1;
    step();
    chk(clk_out === 1'b1, "R7 first edge load", int'(clk_out), 1);

    // R1 R2 R3: sweep every code with power-down off and on
    for (int pd = 0; pd < 2; pd++) begin
      for (int c = 0; c < 4; c++) begin
        ratio_code = 2'(c);
        pwr_down   = 1'(pd);
        measure(hi, lo);
        count_period(hi, lo);
        exp_h = ratio_of(2'(c)) * (pd != 0 ? 16 : 1);
        chk(hi == exp_h, pd != 0 ? "R3 high half" : "R1 R2 high half", hi, exp_h);
        chk(lo == exp_h, pd != 0 ? "R3 low half" : "R1 R2 low half", lo, exp_h);
      end
    end

    // R5: ratio change at start of a high half
    ratio_code = 2'b10; pwr_down = 1'b0;
    measure(hi, lo);
    ratio_code = 2'b11;
    count_period(hi, lo);
    chk(hi == 8, "R5 old high kept", hi, 8);
    chk(lo == 8, "R5 old low kept", lo, 8);
    count_period(hi, lo);
    chk(hi == 1 && lo == 1, "R5 new ratio", hi * 10 + lo, 11);

    // R6: disable during a high half
    ratio_code = 2'b10;
    measure(hi, lo);
    out_en = 1'b0;
    hi = 0;
    while (clk_out === 1'b1) begin hi++; step(); end
    chk(hi == 8, "R6 last high full", hi, 8);
    stayed = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (clk_out !== 1'b0 || clk_out_n !== 1'b1) stayed = 1'b0;
      step();
    end
    chk(stayed, "R4 R6 parked low", int'(stayed), 1);

    // R9: enable while parked, ratio taken at that edge
    ratio_code = 2'b00;
    out_en = 1'b1;
    step();
    chk(clk_out === 1'b1, "R9 enable response", int'(clk_out), 1);
    count_period(hi, lo);
    chk(hi == 2 && lo == 2, "R9 ratio on enable", hi * 10 + lo, 22);

    done = 1;
    finish_run();
  end

endmodule